// File: doc/BRIEF.md
# Supply supervisor control logic

This block is the digital side of a supply supervisor. It takes comparator outputs that are already digital: the power-on level, two detect levels (high and low) and two warning levels (high and low). Each comparator output is 1 while the supply is below its level. From these inputs and a small configuration register it drives a system reset, an interrupt request, a sticky detect flag, a warning flag, two bits that give the cause of the last reset, and a signal that forbids the deepest stop mode.

All comparator inputs pass through two synchroniser flops before any logic uses them. The power-on comparator `por_in` also resets the block asynchronously. While the supply stays below the selected detect level, the detector either holds the system in reset or raises a sticky flag and an interrupt. The configuration decides which. A stop request turns the detector off unless the stop-enable bit is set. With both the enable bit and the stop-enable bit set, the deepest stop mode is blocked.

Configuration bits in `cfg_wdata` / `cfg_q`: bit0 enable, bit1 stop-enable, bit2 reset-enable, bit3 interrupt-enable, bit4 detect level (1 = high comparator), bit5 warning level (1 = high comparator).

Top module: `supply_guard`

## Requirements
- R1: While `por_in` is high and after it falls, until other events occur: `sys_rst`=1, `src_por`=1, `src_lv`=1, `det_flag`=0, `warn_flag`=0, `cfg_q`=6'h05 (enable and reset-enable set).
- R2: After a power-on reset, `sys_rst` stays high while `below_dlo` is 1. It falls at the third rising edge after `below_dlo` reads 0, which allows two synchroniser flops plus a one-cycle release.
- R3: The detector is active only when cfg bit0 is 1 and either `stop_mode` is 0 or cfg bit1 is 1. cfg bit4 selects the comparator it watches: 1 = `below_dhi`, 0 = `below_dlo`.
- R4: With cfg bit2=1 and the detector active, a below condition raises `sys_rst` at the third rising edge after the input changes. `sys_rst` stays high until the selected detect comparator reads 0, and falls at the third edge after that.
- R5: A detect reset sets `src_lv`=1 and clears `src_por`. The status bits change at no other time except a power-on reset.
- R6: With the detector active, cfg bit3=1 and cfg bit2=0, a below condition sets `det_flag`, and `irq` = `det_flag` AND cfg bit3. No reset is generated.
- R7: While the detector is active and the selected warning comparator reads 1, `warn_flag` is set. cfg bit5 selects the comparator: 1 = `below_whi`, 0 = `below_wlo`. The warning flag never drives `irq` or `sys_rst`.
- R8: A cycle with `flag_clr_we`=1 clears `det_flag` (`flag_clr` bit0) and/or `warn_flag` (`flag_clr` bit1). A clear wins over a set in the same cycle. A flag whose condition is still present sets again one cycle later.
- R9: `deep_stop_block` is 1 exactly when cfg bit0 and cfg bit1 are both 1.
- R10: When `cfg_we`=1, `cfg_wdata` is loaded at the rising edge and read back on `cfg_q` after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_in | input | 1 | Power-on comparator, 1 = below power-on level (asynchronous reset) |
| below_dlo | input | 1 | Supply below low detect level |
| below_dhi | input | 1 | Supply below high detect level |
| below_wlo | input | 1 | Supply below low warning level |
| below_whi | input | 1 | Supply below high warning level |
| stop_mode | input | 1 | System is in a stop mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write data |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr | input | 2 | Clear mask: bit0 detect flag, bit1 warning flag |
| cfg_q | output | 6 | Configuration readback |
| sys_rst | output | 1 | System reset request |
| irq | output | 1 | Interrupt request |
| det_flag | output | 1 | Sticky detect flag |
| warn_flag | output | 1 | Warning flag |
| src_por | output | 1 | Last reset came from power-on |
| src_lv | output | 1 | Last reset involved low voltage |
| deep_stop_block | output | 1 | Forbids entry to the deepest stop mode |

## Verification
Two situations can land in the same cycle.

- **Flag clear against flag set.** A flag clear can arrive while the below condition that sets the flag is still present. The bench provokes this by clearing the detect flag while the comparator is held low. It expects the flag to read 0 for exactly one cycle and then 1 again. It then clears the flag after the condition has gone and expects it to stay 0.
- **Power-on release against a new detect reset.** Power-on release can coincide with a detect reset tripping at the high level. Random runs reach this case, and a cycle model written from the requirements judges every cycle.

// File: rtl/supply_guard.sv
module supply_guard #(
  parameter logic [5:0] CFG_RST = 6'h05
) (
  input  logic       clk,
  input  logic       por_in,
  input  logic       below_dlo,
  input  logic       below_dhi,
  input  logic       below_wlo,
  input  logic       below_whi,
  input  logic       stop_mode,
  input  logic       cfg_we,
  input  logic [5:0] cfg_wdata,
  input  logic       flag_clr_we,
  input  logic [1:0] flag_clr,
  output logic [5:0] cfg_q,
  output logic       sys_rst,
  output logic       irq,
  output logic       det_flag,
  output logic       warn_flag,
  output logic       src_por,
  output logic       src_lv,
  output logic       deep_stop_block
);
  localparam int B_EN = 0, B_SE = 1, B_RE = 2, B_IE = 3, B_DH = 4, B_WH = 5;

  logic [3:0] sy1, sy2;
  logic       por_hold, lv_hold;

  wire det_below  = cfg_q[B_DH] ? sy2[1] : sy2[0];
  wire warn_below = cfg_q[B_WH] ? sy2[3] : sy2[2];
  wire active     = cfg_q[B_EN] & (~stop_mode | cfg_q[B_SE]);
  wire trip       = active & cfg_q[B_RE] & det_below & ~sys_rst;
  wire por_next   = por_hold & sy2[0];
  wire lv_next    = trip | (lv_hold & det_below);
  wire det_set    = active & cfg_q[B_IE] & ~cfg_q[B_RE] & det_below;
  wire warn_set   = active & warn_below;
  wire clr_det    = flag_clr_we & flag_clr[0];
  wire clr_warn   = flag_clr_we & flag_clr[1];

  always_ff @(posedge clk or posedge por_in) begin
    if (por_in) begin
      sy1       <= 4'hF;
      sy2       <= 4'hF;
      cfg_q     <= CFG_RST;
      por_hold  <= 1'b1;
      lv_hold   <= 1'b0;
      sys_rst   <= 1'b1;
      det_flag  <= 1'b0;
      warn_flag <= 1'b0;
      src_por   <= 1'b1;
      src_lv    <= 1'b1;
    end else begin
      sy1      <= {below_whi, below_wlo, below_dhi, below_dlo};
      sy2      <= sy1;
      if (cfg_we) cfg_q <= cfg_wdata;
      por_hold <= por_next;
      lv_hold  <= lv_next;
      sys_rst  <= por_next | lv_next;
      if (trip) begin
        src_por <= 1'b0;
        src_lv  <= 1'b1;
      end
      det_flag  <= clr_det  ? 1'b0 : (det_flag  | det_set);
      warn_flag <= clr_warn ? 1'b0 : (warn_flag | warn_set);
    end
  end

  assign irq             = det_flag & cfg_q[B_IE];
  assign deep_stop_block = cfg_q[B_EN] & cfg_q[B_SE];
endmodule

// File: rtl/supply_guard_chk.sv
module supply_guard_chk (
  input logic       clk,
  input logic       por_in,
  input logic       cfg_we,
  input logic [5:0] cfg_wdata,
  input logic       flag_clr_we,
  input logic [1:0] flag_clr,
  input logic [5:0] cfg_q,
  input logic       sys_rst,
  input logic       irq,
  input logic       det_flag,
  input logic       warn_flag,
  input logic       src_por,
  input logic       src_lv
);
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (por_in)
    irq |-> det_flag);
  a_r5_status_moves_with_reset: assert property (@(posedge clk) disable iff (por_in)
    !$stable(src_por) |-> ($rose(sys_rst) && src_lv));
  a_r5_lv_stays: assert property (@(posedge clk) disable iff (por_in)
    src_lv);
  a_r8_clear_det: assert property (@(posedge clk) disable iff (por_in)
    (flag_clr_we && flag_clr[0]) |=> !det_flag);
  a_r8_clear_warn: assert property (@(posedge clk) disable iff (por_in)
    (flag_clr_we && flag_clr[1]) |=> !warn_flag);
  a_r10_cfg_load: assert property (@(posedge clk) disable iff (por_in)
    cfg_we |=> (cfg_q == $past(cfg_wdata)));
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (por_in)
    !cfg_we |=> $stable(cfg_q));
endmodule

bind supply_guard supply_guard_chk u_chk (
  .clk(clk), .por_in(por_in), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .flag_clr_we(flag_clr_we), .flag_clr(flag_clr), .cfg_q(cfg_q),
  .sys_rst(sys_rst), .irq(irq), .det_flag(det_flag), .warn_flag(warn_flag),
  .src_por(src_por), .src_lv(src_lv)
);

// File: tb/test_supply_guard.sv
module test_supply_guard;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic por_in = 1'b1;
  logic [3:0] below = 4'hF;
  logic stop_mode = 1'b0, cfg_we = 1'b0, flag_clr_we = 1'b0;
  logic [5:0] cfg_wdata = '0;
  logic [1:0] flag_clr = '0;
  logic [5:0] cfg_q;
  logic sys_rst, irq, det_flag, warn_flag, src_por, src_lv, deep_stop_block;
  int total = 0, bad = 0;

  always #(PERIOD/2) clk = ~clk;

  supply_guard i_supply_guard (
    .clk(clk), .por_in(por_in),
    .below_dlo(below[0]), .below_dhi(below[1]), .below_wlo(below[2]), .below_whi(below[3]),
    .stop_mode(stop_mode), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .flag_clr_we(flag_clr_we), .flag_clr(flag_clr), .cfg_q(cfg_q),
    .sys_rst(sys_rst), .irq(irq), .det_flag(det_flag), .warn_flag(warn_flag),
    .src_por(src_por), .src_lv(src_lv), .deep_stop_block(deep_stop_block)
  );

  // cycle model written from the requirements
  logic [3:0] m1, m2;
  logic [5:0] mcfg;
  logic mph, mlh, mrst, mdf, mwf, mpor, mlv;
  always @(posedge clk or posedge por_in) begin
    if (por_in) begin
      m1 <= 4'hF; m2 <= 4'hF; mcfg <= 6'h05; mph <= 1'b1; mlh <= 1'b0;
      mrst <= 1'b1; mdf <= 1'b0; mwf <= 1'b0; mpor <= 1'b1; mlv <= 1'b1;
    end else begin
      automatic logic act  = mcfg[0] && (!stop_mode || mcfg[1]);
      automatic logic dsel = mcfg[4] ? m2[1] : m2[0];
      automatic logic wsel = mcfg[5] ? m2[3] : m2[2];
      automatic logic hit  = act && mcfg[2] && dsel && !mrst;
      automatic logic ph   = mph && m2[0];
      automatic logic lh   = hit || (mlh && dsel);
      m1 <= below; m2 <= m1;
      if (cfg_we) mcfg <= cfg_wdata;
      mph <= ph; mlh <= lh; mrst <= ph || lh;
      if (hit) begin mpor <= 1'b0; mlv <= 1'b1; end
      if (flag_clr_we && flag_clr[0]) mdf <= 1'b0;
      else if (act && mcfg[3] && !mcfg[2] && dsel) mdf <= 1'b1;
      if (flag_clr_we && flag_clr[1]) mwf <= 1'b0;
      else if (act && wsel) mwf <= 1'b1;
    end
  end

  function automatic logic [12:0] model_vec(input logic [5:0] c, input logic r, df, wf, p, l);
    return {c, r, df & c[3], df, wf, p, l, c[0] & c[1]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; flag_clr_we = 1'b0;
    check("model", {cfg_q, sys_rst, irq, det_flag, warn_flag, src_por, src_lv, deep_stop_block},
          model_vec(mcfg, mrst, mdf, mwf, mpor, mlv));
  endtask

  task automatic wcfg(input logic [5:0] v);
    cfg_wdata = v; cfg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (PERIOD * 200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    @(negedge clk); @(negedge clk);
    check("R1 reset state", {cfg_q, sys_rst, det_flag, warn_flag, src_por, src_lv}, {6'h05, 5'b10011});
    por_in = 1'b0;
    repeat (3) tick();
    check("R2 hold while below", sys_rst, 1);
    check("R1 state after release", {cfg_q, src_por, src_lv}, {6'h05, 2'b11});
    below = 4'h0;
    tick(); tick();
    check("R2 still held", sys_rst, 1);
    tick();
    check("R2 released", sys_rst, 0);
    // R10 / R9
    wcfg(6'h03);
    check("R10 readback", cfg_q, 6'h03);
    check("R9 block set", deep_stop_block, 1);
    wcfg(6'h05);
    check("R9 block clear", deep_stop_block, 0);
    // R4 / R5
    below[0] = 1'b1;
    tick(); tick();
    check("R4 not yet", sys_rst, 0);
    tick();
    check("R4 reset raised", sys_rst, 1);
    check("R5 status", {src_por, src_lv}, 2'b01);
    repeat (5) tick();
    check("R4 held", sys_rst, 1);
    below[0] = 1'b0;
    tick(); tick();
    check("R4 held until recovery", sys_rst, 1);
    tick();
    check("R4 released", sys_rst, 0);
    check("R5 status kept", {src_por, src_lv}, 2'b01);
    // R3 stop disables
    stop_mode = 1'b1; below[0] = 1'b1;
    repeat (5) tick();
    check("R3 stop disables", sys_rst, 0);
    below[0] = 1'b0; repeat (3) tick(); stop_mode = 1'b0;
    wcfg(6'h15); below[1] = 1'b1;
    repeat (3) tick();
    check("R3 high level trips", sys_rst, 1);
    below[1] = 1'b0; repeat (3) tick();
    check("R3 high level recovers", sys_rst, 0);
    // R6 / R8
    wcfg(6'h09); below[0] = 1'b1;
    repeat (3) tick();
    check("R6 flag and irq", {det_flag, irq, sys_rst}, 3'b110);
    flag_clr = 2'b01; flag_clr_we = 1'b1;
    tick();
    check("R8 clear wins", det_flag, 0);
    tick();
    check("R8 sets again", det_flag, 1);
    below[0] = 1'b0; repeat (3) tick();
    flag_clr = 2'b01; flag_clr_we = 1'b1;
    tick(); tick();
    check("R8 stays clear", det_flag, 0);
    // R7
    wcfg(6'h01); below[2] = 1'b1;
    repeat (3) tick();
    check("R7 warning", {warn_flag, irq, sys_rst}, 3'b100);
    below[2] = 1'b0; wcfg(6'h21); repeat (3) tick();
    flag_clr = 2'b10; flag_clr_we = 1'b1; tick();
    check("R8 warn cleared", warn_flag, 0);
    below[3] = 1'b1; repeat (3) tick();
    check("R7 high warning level", warn_flag, 1);
    // random phase checked against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) below[$urandom_range(0, 3)] ^= 1'b1;
      if ($urandom_range(0, 15) == 0) stop_mode = $urandom_range(0, 1);
      if ($urandom_range(0, 19) == 0) begin cfg_wdata = 6'($urandom); cfg_we = 1'b1; end
      if ($urandom_range(0, 9) == 0) begin flag_clr = 2'($urandom); flag_clr_we = 1'b1; end
      if ($urandom_range(0, 499) == 0) begin
        por_in = 1'b1; tick(); por_in = 1'b0;
      end
      tick();
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule